// File: doc/BRIEF.md
# Power Control Register with Low-Power Mode Selector

This block is a single memory-mapped control register for a chip's power manager, paired with the logic that turns the processor's deep-sleep request into a concrete low-power mode. Software writes it through a simple write strobe with a data word, and reads it back as a data word. The register holds an unlock bit that permits writes into the backup domain, a 3-bit threshold code and an enable for a supply voltage detector, and two mode bits that set what deep sleep means.

Two bits of the register are write-one strobes and not storage. One clears a standby status flag at the next clock edge. The other clears a wakeup status flag after a fixed two-cycle delay. Both strobe bits always read as zero. The status flags are set by events from outside the block. When a set event and a clear land on the same edge, the set wins.

When deep sleep is requested while the block is in Run, it latches either Stop or Standby from the mode-select bit. In Stop it also latches the regulator setting. The mode holds until a wake event brings it back to Run.

Top module: `pwr_ctl_top`

## Requirements
- R1: After synchronous reset, rdata is 0, bkp_wr_en, det_en, det_level, sb_flag, wu_flag and reg_lowpwr are 0, and lp_mode is Run (code 0).
- R2: A write stores wdata bit 8 into the backup unlock, bits 7:5 into the threshold code and bit 4 into the detector enable. All three read back at the same positions and drive bkp_wr_en, det_level and det_en. Codes 0 to 7 select thresholds in ascending order.
- R3: wdata bit 1 (standby select) and bit 0 (low-power regulator) are stored and read back at the same positions.
- R4: Bits 3 and 2 and every bit from 9 upward always read as 0, and writes to them store nothing.
- R5: Writing 1 to bit 3 clears sb_flag at the edge that accepts the write. Writing 0 there leaves the flag unchanged. sb_set raises sb_flag.
- R6: Writing 1 to bit 2 clears wu_flag at the second rising edge after the write is accepted, and not earlier. Writing 0 there has no effect. wu_set raises wu_flag.
- R7: A set event on the same edge as a pending clear leaves the flag at 1.
- R8: With lp_mode at Run, a high deep_sleep_req gives lp_mode Stop (1) at the next edge if bit 1 is 0, and Standby (2) if bit 1 is 1.
- R9: In Stop, reg_lowpwr equals the bit 0 value latched on entry. In Standby and Run, reg_lowpwr is 0.
- R10: While not in Run, lp_mode and reg_lowpwr do not change when the register changes or the request falls. A high wake_evt returns the block to Run at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Register readback |
| sb_set | input | 1 | Standby flag set event |
| wu_set | input | 1 | Wakeup flag set event |
| sb_flag | output | 1 | Standby status flag |
| wu_flag | output | 1 | Wakeup status flag |
| deep_sleep_req | input | 1 | Deep-sleep request from the processor |
| wake_evt | input | 1 | Wake event returning to Run |
| bkp_wr_en | output | 1 | Backup domain write permission |
| det_level | output | 3 | Voltage detector threshold code |
| det_en | output | 1 | Voltage detector enable |
| lp_mode | output | 2 | Current mode: 0 Run, 1 Stop, 2 Standby |
| reg_lowpwr | output | 1 | Regulator low-power select |

## Verification
The bench builds the block with its defaults: a 32-bit data word and a wakeup clear delay of 2. With a 32-bit word, random writes reach the reserved upper bits as well as every field. With a delay of 2, the wakeup pipeline has a single stage, so the cycle-exact clear and the same-edge set-versus-clear case can both be observed. Directed sequences cover all four settings of the two mode bits, with register rewrites during sleep and wake-ups afterwards.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

    localparam int CTRL_BITS   = 9;
    localparam int BKP_BIT     = 8;
    localparam int LVL_LSB     = 5;
    localparam int LVL_W       = 3;
    localparam int DET_BIT     = 4;
    localparam int SBCLR_BIT   = 3;
    localparam int WUCLR_BIT   = 2;
    localparam int SBYSEL_BIT  = 1;
    localparam int LPREG_BIT   = 0;

    typedef enum logic [1:0] {
        LPM_RUN     = 2'd0,
        LPM_STOP    = 2'd1,
        LPM_STANDBY = 2'd2
    } lp_mode_e;

    typedef struct packed {
        logic             bkp_unlock;
        logic [LVL_W-1:0] det_level;
        logic             det_en;
        logic             sby_sel;
        logic             lp_reg;
    } ctrl_t;

    typedef struct packed {
        logic sb_clr;
        logic wu_clr;
    } strobe_t;

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_BITS-1:0] w);
        ctrl_t c;
        c.bkp_unlock = w[BKP_BIT];
        c.det_level  = w[LVL_LSB +: LVL_W];
        c.det_en     = w[DET_BIT];
        c.sby_sel    = w[SBYSEL_BIT];
        c.lp_reg     = w[LPREG_BIT];
        return c;
    endfunction

    function automatic logic [CTRL_BITS-1:0] pack_ctrl(input ctrl_t c);
        logic [CTRL_BITS-1:0] w;
        w                       = '0;
        w[BKP_BIT]              = c.bkp_unlock;
        w[LVL_LSB +: LVL_W]     = c.det_level;
        w[DET_BIT]              = c.det_en;
        w[SBYSEL_BIT]           = c.sby_sel;
        w[LPREG_BIT]            = c.lp_reg;
        return w;
    endfunction

    function automatic lp_mode_e pick_mode(input ctrl_t c);
        return c.sby_sel ? LPM_STANDBY : LPM_STOP;
    endfunction

endpackage

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs
    import pwr_ctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output strobe_t           strb
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= unpack_ctrl(wdata[CTRL_BITS-1:0]);
        end
    end

    always_comb begin
        strb.sb_clr = wr_en & wdata[SBCLR_BIT];
        strb.wu_clr = wr_en & wdata[WUCLR_BIT];
    end

    assign ctrl  = ctrl_q;
    assign rdata = DATA_W'(pack_ctrl(ctrl_q));

    // R2
    field_readback_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rdata[BKP_BIT:DET_BIT] == $past(wdata[BKP_BIT:DET_BIT])));

    // R3
    mode_bits_readback_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rdata[SBYSEL_BIT:LPREG_BIT] == $past(wdata[SBYSEL_BIT:LPREG_BIT])));

    // R4
    strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rdata[SBCLR_BIT:WUCLR_BIT] == 2'b00));

endmodule

// File: rtl/pwr_ctl_flags.sv
module pwr_ctl_flags
    import pwr_ctl_pkg::*;
#(
    parameter int WU_CLR_DELAY = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strb,
    input  logic    sb_set,
    input  logic    wu_set,
    output logic    sb_flag,
    output logic    wu_flag
);

    localparam int STG = (WU_CLR_DELAY > 1) ? WU_CLR_DELAY - 1 : 1;

    logic [STG-1:0] wu_pipe;
    logic           wu_fire;

    generate
        if (STG == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) wu_pipe <= '0;
                else     wu_pipe <= strb.wu_clr;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) wu_pipe <= '0;
                else     wu_pipe <= {wu_pipe[STG-2:0], strb.wu_clr};
            end
        end
    endgenerate

    assign wu_fire = wu_pipe[STG-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sb_flag <= 1'b0;
        end else if (sb_set) begin
            sb_flag <= 1'b1;
        end else if (strb.sb_clr) begin
            sb_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wu_flag <= 1'b0;
        end else if (wu_set) begin
            wu_flag <= 1'b1;
        end else if (wu_fire) begin
            wu_flag <= 1'b0;
        end
    end

    // R5
    sb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (strb.sb_clr && !sb_set) |=> !sb_flag);

    // R7
    wu_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wu_set |=> wu_flag);

    generate
        if (WU_CLR_DELAY == 2) begin : g_chk2
            // R6
            wu_clear_late_chk: assert property (@(posedge clk) disable iff (rst)
                ($past(strb.wu_clr) && !wu_set) |=> !wu_flag);
            // R6
            wu_clear_not_early_chk: assert property (@(posedge clk) disable iff (rst)
                (wu_flag && !$past(strb.wu_clr)) |=> wu_flag);
        end
    endgenerate

endmodule

// File: rtl/pwr_ctl_mode.sv
module pwr_ctl_mode
    import pwr_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctrl_t    ctrl,
    input  logic     deep_sleep_req,
    input  logic     wake_evt,
    output lp_mode_e mode,
    output logic     reg_lp
);

    lp_mode_e mode_q;
    logic     reg_lp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= LPM_RUN;
            reg_lp_q <= 1'b0;
        end else if (mode_q == LPM_RUN) begin
            if (deep_sleep_req) begin
                mode_q   <= pick_mode(ctrl);
                reg_lp_q <= !ctrl.sby_sel && ctrl.lp_reg;
            end
        end else if (wake_evt) begin
            mode_q   <= LPM_RUN;
            reg_lp_q <= 1'b0;
        end
    end

    assign mode   = mode_q;
    assign reg_lp = reg_lp_q;

    // R8
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == LPM_RUN && deep_sleep_req) |=>
            (mode == ($past(ctrl.sby_sel) ? LPM_STANDBY : LPM_STOP)));

    // R9
    regulator_only_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != LPM_STOP) |-> !reg_lp);

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != LPM_RUN && !wake_evt) |=> ($stable(mode) && $stable(reg_lp)));

    // R10
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != LPM_RUN && wake_evt) |=> (mode == LPM_RUN));

endmodule

// File: rtl/pwr_ctl_top.sv
module pwr_ctl_top
    import pwr_ctl_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int WU_CLR_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sb_set,
    input  logic              wu_set,
    output logic              sb_flag,
    output logic              wu_flag,
    input  logic              deep_sleep_req,
    input  logic              wake_evt,
    output logic              bkp_wr_en,
    output logic [2:0]        det_level,
    output logic              det_en,
    output logic [1:0]        lp_mode,
    output logic              reg_lowpwr
);

    ctrl_t    ctrl;
    strobe_t  strb;
    lp_mode_e mode;

    pwr_ctl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wdata (wdata),
        .rdata (rdata),
        .ctrl  (ctrl),
        .strb  (strb)
    );

    pwr_ctl_flags #(.WU_CLR_DELAY(WU_CLR_DELAY)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .strb    (strb),
        .sb_set  (sb_set),
        .wu_set  (wu_set),
        .sb_flag (sb_flag),
        .wu_flag (wu_flag)
    );

    pwr_ctl_mode u_mode (
        .clk            (clk),
        .rst            (rst),
        .ctrl           (ctrl),
        .deep_sleep_req (deep_sleep_req),
        .wake_evt       (wake_evt),
        .mode           (mode),
        .reg_lp         (reg_lowpwr)
    );

    assign bkp_wr_en = ctrl.bkp_unlock;
    assign det_level = ctrl.det_level;
    assign det_en    = ctrl.det_en;
    assign lp_mode   = mode;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rdata == '0 && lp_mode == 2'd0 && !sb_flag && !wu_flag));

endmodule

// File: tb/pwr_ctl_top_tb.sv
`timescale 1ns/1ps
module pwr_ctl_top_tb;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          sb_set, wu_set, sb_flag, wu_flag;
    logic          deep_sleep_req, wake_evt;
    logic          bkp_wr_en, det_en, reg_lowpwr;
    logic [2:0]    det_level;
    logic [1:0]    lp_mode;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pwr_ctl_top #(.DATA_W(DW), .WU_CLR_DELAY(2)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .sb_set(sb_set), .wu_set(wu_set), .sb_flag(sb_flag), .wu_flag(wu_flag),
        .deep_sleep_req(deep_sleep_req), .wake_evt(wake_evt),
        .bkp_wr_en(bkp_wr_en), .det_level(det_level), .det_en(det_en),
        .lp_mode(lp_mode), .reg_lowpwr(reg_lowpwr)
    );

    function automatic logic [DW-1:0] exp_read(input logic [DW-1:0] w);
        return w & 32'h0000_01F3;
    endfunction

    function automatic logic [1:0] exp_mode(input logic [1:0] bits);
        return bits[1] ? 2'd2 : 2'd1;
    endfunction

    function automatic logic exp_reg(input logic [1:0] bits);
        return !bits[1] && bits[0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [DW-1:0] w);
        wr_en = 1'b1;
        wdata = w;
        step();
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] w;
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wdata = '0; sb_set = 1'b0; wu_set = 1'b0;
        deep_sleep_req = 1'b0; wake_evt = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rdata", rdata, 0);
        check("R1 outputs", {bkp_wr_en, det_level, det_en, reg_lowpwr}, 0);
        check("R1 flags", {sb_flag, wu_flag}, 0);
        check("R1 mode", lp_mode, 0);

        // R4 all-ones write: reserved and strobe bits read 0
        write('1);
        check("R4 all ones", rdata, 32'h1F3);

        // R2 R3 R4 random writes
        for (int i = 0; i < 40; i++) begin
            w = $urandom;
            write(w);
            check("R2 R3 R4 readback", rdata, exp_read(w));
            check("R2 bkp_wr_en", bkp_wr_en, w[8]);
            check("R2 det_level", det_level, w[7:5]);
            check("R2 det_en", det_en, w[4]);
        end
        // R2 every threshold code
        for (int c = 0; c < 8; c++) begin
            write(32'(c) << 5);
            check("R2 level code", det_level, c);
        end

        // R5 standby flag
        sb_set = 1'b1; step(); sb_set = 1'b0;
        check("R5 sb set", sb_flag, 1);
        write(32'hFFFF_FFF7);
        check("R5 zero in bit3 no effect", sb_flag, 1);
        write(32'h8);
        check("R5 sb cleared", sb_flag, 0);

        // R6 wakeup flag timing
        wu_set = 1'b1; step(); wu_set = 1'b0;
        check("R6 wu set", wu_flag, 1);
        write(32'h4);
        check("R6 not cleared after first edge", wu_flag, 1);
        step();
        check("R6 cleared after second edge", wu_flag, 0);
        wu_set = 1'b1; step(); wu_set = 1'b0;
        write(32'hFFFF_FFFB);
        step();
        check("R6 zero in bit2 no effect", wu_flag, 1);

        // R7 set wins over delayed clear
        write(32'h4);
        wu_set = 1'b1; step(); wu_set = 1'b0;
        check("R7 set wins", wu_flag, 1);
        step();
        check("R7 flag stays", wu_flag, 1);

        // R8 R9 R10 all four mode-bit combinations
        for (int c = 0; c < 4; c++) begin
            write(32'(c));
            wake_evt = 1'b1; step(); wake_evt = 1'b0;
            check("R10 wake in run no effect", lp_mode, 0);
            deep_sleep_req = 1'b1; step();
            check("R8 mode entry", lp_mode, exp_mode(2'(c)));
            check("R9 regulator", reg_lowpwr, exp_reg(2'(c)));
            deep_sleep_req = 1'b0;
            write(32'(c ^ 3));
            step();
            check("R10 mode held", lp_mode, exp_mode(2'(c)));
            check("R10 regulator held", reg_lowpwr, exp_reg(2'(c)));
            wake_evt = 1'b1; step(); wake_evt = 1'b0;
            check("R10 wake to run", lp_mode, 0);
            check("R9 regulator in run", reg_lowpwr, 0);
        end

        finish_run();
    end

endmodule